// File: doc/BRIEF.md
# Sum-of-Squares Result Checker

This block checks a pair of results from a rotation engine while the engine keeps running. Each accepted pair is two signed fixed-point words. The block squares both words. In circular mode it adds the two squares, which is the cos² + sin² identity. In hyperbolic mode it subtracts the second square from the first, which is the cosh² − sinh² identity. A correct pair gives one, so the block tests whether the combined value falls inside a narrow tolerance window around one. It returns one verdict for each pair: pass, or error.

The checker accepts one pair per clock. A pair strobed with `in_valid` produces its verdict on `chk_valid`/`chk_err` two cycles later. A two-state flag machine (states CLEAN and FAULT) records that some failure has occurred. On a failing verdict the machine takes the SET transition from CLEAN to FAULT. Raising `flag_clear` takes the CLEAR transition from FAULT back to CLEAN. In every other case it takes the HOLD transition and keeps its state. When a failing verdict and a clear land on the same edge, the failing verdict wins.

Top module: `sos_check`

## Requirements
- R1: `in_a` and `in_b` are 24-bit two's-complement values with 22 fractional bits, so 1.0 is 0x400000. Only their squares enter the result, so negating either word never changes the verdict.
- R2: With `sys_hyp` = 0 (circular), the value tested is in_a² + in_b².
- R3: With `sys_hyp` = 1 (hyperbolic), the value tested is in_a² − in_b², the first square minus the second.
- R4: The squared value has 44 fractional bits. It passes when it lies inside the closed band [2^44 − 17592187, 2^44 + 17592187]. This band is ±1e-6 rounded outward to whole LSBs.
- R5: For every pair accepted with `in_valid` = 1, exactly one verdict appears: `chk_err` = 1 when the value is outside the band and 0 when it is inside. A new pair may be accepted on every cycle.
- R6: `chk_valid` is high exactly in the cycle two clock edges after a cycle with `in_valid` high, and low otherwise.
- R7: `err_sticky` rises on the same edge that presents a failing verdict. It then stays high until it is cleared.
- R8: `flag_clear` sampled high returns `err_sticky` to 0. The only exception is a failing verdict presented on that same edge, which keeps it at 1.
- R9: While `rst_n` is low, `chk_valid`, `chk_err` and `err_sticky` are all 0.
- R10: While `in_valid` is low, the values on `in_a`, `in_b` and `sys_hyp` produce no verdict and leave `err_sticky` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pair present on this cycle |
| sys_hyp | input | 1 | 0 selects circular (sum), 1 selects hyperbolic (difference) |
| in_a | input | 24 | First result word, signed, 22 fractional bits |
| in_b | input | 24 | Second result word, signed, 22 fractional bits |
| flag_clear | input | 1 | Return the sticky flag to CLEAN |
| chk_valid | output | 1 | Verdict present |
| chk_err | output | 1 | Verdict is out of band (qualified by chk_valid) |
| err_sticky | output | 1 | A failing verdict has occurred since the last clear |

## Verification
Several properties are checked on every clock: the two-cycle spacing between `in_valid` and `chk_valid`, the non-negative range of the registered squares, the flag's SET, HOLD and CLEAR transitions including the failure-over-clear priority, and that every failing verdict is covered by the flag. Whether the arithmetic is right can only be shown by the bench's scenarios. The bench computes each expected verdict exactly. Its directed pairs sit a few LSBs on either side of both band edges, use negated operands, and swap the operand order in hyperbolic mode. A stream of random near-identity pairs then tests pass and fail back to back.

// File: rtl/sos_pkg.sv
package sos_pkg;
    // Sticky flag machine states
    typedef enum logic [0:0] {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } flag_state_t;
endpackage

// File: rtl/sos_square_stage.sv
module sos_square_stage #(
    parameter int DATA_W = 24,
    parameter int SQ_W   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sys_hyp,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              sq_valid,
    output logic              sq_hyp,
    output logic [SQ_W-1:0]   sq_a,
    output logic [SQ_W-1:0]   sq_b
);
    logic signed [SQ_W-1:0] prod_a;
    logic signed [SQ_W-1:0] prod_b;

    always_comb begin
        prod_a = $signed(in_a) * $signed(in_a);
        prod_b = $signed(in_b) * $signed(in_b);
    end

    // First pipeline stage: both squares; operands held when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_valid <= 1'b0;
            sq_hyp   <= 1'b0;
            sq_a     <= '0;
            sq_b     <= '0;
        end else begin
            sq_valid <= in_valid;
            if (in_valid) begin
                sq_hyp <= sys_hyp;
                sq_a   <= prod_a;
                sq_b   <= prod_b;
            end
        end
    end

    // R1: a square of a signed word never reaches the top bit
    a_r1_square_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (!sq_a[SQ_W-1] && !sq_b[SQ_W-1]));
endmodule

// File: rtl/sos_band_compare.sv
module sos_band_compare #(
    parameter int          SQ_W    = 48,
    parameter int          SQ_FRAC = 44,
    parameter int unsigned TOL_Q   = 17592187
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sq_valid,
    input  logic            sq_hyp,
    input  logic [SQ_W-1:0] sq_a,
    input  logic [SQ_W-1:0] sq_b,
    output logic            verdict_fail,
    output logic            chk_valid,
    output logic            chk_err
);
    localparam int CMB_W = SQ_W + 1;
    localparam logic signed [CMB_W-1:0] ONE_Q = CMB_W'(1) << SQ_FRAC;
    localparam logic signed [CMB_W-1:0] TOL_C = CMB_W'(TOL_Q);
    localparam logic signed [CMB_W-1:0] LO_Q  = ONE_Q - TOL_C;
    localparam logic signed [CMB_W-1:0] HI_Q  = ONE_Q + TOL_C;

    logic signed [CMB_W-1:0] ext_a;
    logic signed [CMB_W-1:0] ext_b;
    logic signed [CMB_W-1:0] cmb;
    logic                    in_band;

    always_comb begin
        ext_a = $signed({1'b0, sq_a});
        ext_b = $signed({1'b0, sq_b});
        // circular adds, hyperbolic subtracts second from first
        cmb = sq_hyp ? (ext_a - ext_b) : (ext_a + ext_b);
        in_band = (cmb >= LO_Q) && (cmb <= HI_Q);
        verdict_fail = sq_valid && !in_band;
    end

    // Second pipeline stage: registered verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_err   <= 1'b0;
        end else begin
            chk_valid <= sq_valid;
            chk_err   <= verdict_fail;
        end
    end

    // R4: an exact unit value must pass
    a_r4_unit_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && cmb == ONE_Q) |=> (chk_valid && !chk_err));
    // R5: each squared pair yields exactly one verdict
    a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> chk_valid);
endmodule

// File: rtl/sos_flag_fsm.sv
module sos_flag_fsm
    import sos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fail_now,
    input  logic flag_clear,
    output logic err_sticky
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: if (fail_now)                 state_d = ST_FAULT;  // SET
            ST_FAULT: if (flag_clear && !fail_now)  state_d = ST_CLEAN;  // CLEAR
            default:                                state_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        err_sticky = (state_q == ST_FAULT);
    end

    // R7: fault holds without a clear
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !flag_clear) |=> err_sticky);
    // R8: a failing verdict beats a simultaneous clear
    a_r8_fail_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fail_now |=> err_sticky);
    // R8: clear without a failure returns to clean
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear && !fail_now) |=> !err_sticky);
endmodule

// File: rtl/sos_check.sv
module sos_check #(
    parameter int          DATA_W = 24,
    parameter int          FRAC_W = 22,
    parameter int unsigned TOL_Q  = 17592187
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sys_hyp,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              flag_clear,
    output logic              chk_valid,
    output logic              chk_err,
    output logic              err_sticky
);
    localparam int SQ_W    = 2 * DATA_W;
    localparam int SQ_FRAC = 2 * FRAC_W;

    logic            sq_valid;
    logic            sq_hyp;
    logic [SQ_W-1:0] sq_a;
    logic [SQ_W-1:0] sq_b;
    logic            verdict_fail;

    sos_square_stage #(.DATA_W(DATA_W), .SQ_W(SQ_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_hyp(sys_hyp),
        .in_a(in_a), .in_b(in_b), .sq_valid(sq_valid), .sq_hyp(sq_hyp),
        .sq_a(sq_a), .sq_b(sq_b)
    );

    sos_band_compare #(.SQ_W(SQ_W), .SQ_FRAC(SQ_FRAC), .TOL_Q(TOL_Q)) u_cmp (
        .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_hyp(sq_hyp),
        .sq_a(sq_a), .sq_b(sq_b), .verdict_fail(verdict_fail),
        .chk_valid(chk_valid), .chk_err(chk_err)
    );

    sos_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .fail_now(verdict_fail),
        .flag_clear(flag_clear), .err_sticky(err_sticky)
    );

    // R6: verdict two edges after the strobe, and never without one
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 chk_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !chk_valid);
    // R7: every failing verdict is covered by the flag
    a_r7_flag_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_err) |-> err_sticky);
endmodule

// File: tb/sim_sos_check.sv
module sim_sos_check;
    localparam int CLK_NS = 10;
    localparam longint ONE = longint'(1) << 44;
    localparam longint TOL = 17592187;
    localparam logic [23:0] UNIT = 24'h400000;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, sys_hyp, flag_clear;
    logic [23:0] in_a, in_b;
    logic chk_valid, chk_err, err_sticky;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit h1_v, h1_f, h2_v, h2_f, clr_d1, stk_m;
    string r1_tag, r2_tag;

    always #(CLK_NS/2) clk = ~clk;

    sos_check u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_hyp(sys_hyp),
        .in_a(in_a), .in_b(in_b), .flag_clear(flag_clear),
        .chk_valid(chk_valid), .chk_err(chk_err), .err_sticky(err_sticky)
    );

    function automatic bit model_fail(logic [23:0] a, logic [23:0] b, bit h);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint v = h ? (sa*sa - sb*sb) : (sa*sa + sb*sb);
        return !((v >= ONE - TOL) && (v <= ONE + TOL));
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(bit v, logic [23:0] a, logic [23:0] b, bit h, bit clr, string req);
        @(negedge clk);
        stk_m = (h2_v && h2_f) ? 1'b1 : (clr_d1 ? 1'b0 : stk_m);
        check({r2_tag, "/R6"}, chk_valid, h2_v, "chk_valid");
        if (h2_v) check({r2_tag, "/R5"}, chk_err, h2_f, "chk_err");
        check({r2_tag, "/R7/R8"}, err_sticky, stk_m, "err_sticky");
        h2_v = h1_v; h2_f = h1_f; r2_tag = r1_tag;
        h1_v = v; h1_f = v ? model_fail(a, b, h) : 1'b0; r1_tag = req;
        clr_d1 = clr;
        in_valid = v; in_a = a; in_b = b; sys_hyp = h; flag_clear = clr;
    endtask

    task automatic idle(int n, bit clr, string req);
        for (int i = 0; i < n; i++) step(0, 24'h7FFFFF, 24'h7FFFFF, 0, clr, req);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R6 watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 0; in_valid = 0; sys_hyp = 0; flag_clear = 0; in_a = 0; in_b = 0;
        h1_v = 0; h1_f = 0; h2_v = 0; h2_f = 0; clr_d1 = 0; stk_m = 0;
        r1_tag = "R6"; r2_tag = "R6";
        repeat (3) @(negedge clk);
        in_valid = 1; in_a = 24'h7FFFFF; in_b = 24'h7FFFFF;   // strobe during reset
        @(negedge clk);
        check("R9", chk_valid, 1'b0, "chk_valid in reset");
        check("R9", chk_err, 1'b0, "chk_err in reset");
        check("R9", err_sticky, 1'b0, "err_sticky in reset");
        in_valid = 0;
        rst_n = 1;

        // R2 exact unit, R4 edges on both sides of one
        step(1, UNIT, 24'h0, 0, 0, "R2");
        step(1, UNIT + 24'd2, 24'h0, 0, 0, "R4");
        step(1, UNIT - 24'd2, 24'h0, 0, 0, "R4");
        step(1, UNIT + 24'd3, 24'h0, 0, 0, "R4");
        step(1, UNIT - 24'd3, 24'h0, 0, 0, "R4");
        idle(2, 0, "R7");
        idle(1, 1, "R8");
        idle(2, 0, "R8");

        // R1 negated operands
        step(1, 24'hC00000, 24'h0, 0, 0, "R1");
        step(1, 24'h0, 24'hC00000, 0, 0, "R1");
        step(1, 24'hC00000 - 24'd2, 24'h0, 0, 0, "R1");
        step(1, UNIT + 24'd3, -24'sd2753, 1, 0, "R1");

        // R3 hyperbolic: tight band edge and operand order
        step(1, UNIT + 24'd3, 24'd2753, 1, 0, "R3");
        step(1, UNIT + 24'd3, 24'd2752, 1, 0, "R3");
        step(1, 24'd2753, UNIT + 24'd3, 1, 0, "R3");
        step(1, UNIT + 24'd3, 24'd2753, 0, 0, "R2");
        idle(2, 0, "R7");
        idle(1, 1, "R8");
        idle(2, 0, "R8");

        // R10 garbage with strobe low
        step(0, 24'h7FFFFF, 24'h123456, 1, 0, "R10");
        step(0, 24'h800000, 24'h000001, 0, 0, "R10");
        idle(3, 0, "R10");

        // R8 failure and clear on the same edge
        step(1, 24'h7FFFFF, 24'h7FFFFF, 0, 0, "R8");
        idle(1, 1, "R8");
        idle(2, 0, "R8");
        idle(1, 1, "R8");
        // R8 clear together with a passing verdict
        step(1, UNIT, 24'h0, 0, 0, "R8");
        step(1, UNIT, 24'h0, 1, 1, "R8");
        idle(2, 0, "R8");

        // R5 random near-identity stream, back to back
        for (int i = 0; i < 800; i++) begin
            logic [23:0] a, b;
            int pert;
            bit h;
            real r;
            h = $urandom_range(0, 1);
            pert = int'($urandom_range(0, 8)) - 4;
            if ($urandom_range(0, 9) == 0) begin
                a = 24'($urandom); b = 24'($urandom);
            end else if (!h) begin
                a = 24'($urandom_range(0, 32'h400000));
                r = $sqrt(real'(ONE) - real'(longint'(a)) * real'(longint'(a)));
                b = 24'($rtoi(r + 0.5) + pert);
            end else begin
                b = 24'($urandom_range(0, 32'h200000));
                r = $sqrt(real'(ONE) + real'(longint'(b)) * real'(longint'(b)));
                a = 24'($rtoi(r + 0.5) + pert);
            end
            if ($urandom_range(0, 1)) a = -a;
            if ($urandom_range(0, 1)) b = -b;
            step($urandom_range(0, 7) != 0, a, b, h, $urandom_range(0, 15) == 0, "R5");
        end
        idle(3, 0, "R6");

        finished = 1;
        summary();
        $finish;
    end
endmodule